// File: doc/BRIEF.md
# Multi-Byte Stack Transfer Engine

This block moves a register value of one to eight bytes between a 64-bit register and a byte-wide stack memory, one byte per clock. It sits beside an instruction sequencer that handles multi-byte push and pull of the accumulator, the two index registers and the status word. The sequencer raises a start strobe together with a direction, a register select, the size operand byte fetched after the opcode, and (for a push) the value to store. The engine owns the 16-bit stack pointer and drives a memory port whose read data is expected in the same cycle as the address.

A push stores the highest transferred byte lane first and works down to bits 7:0, writing at the stack pointer and then decrementing it. A pull first increments the stack pointer and then reads, filling the result from bits 7:0 upward; lanes beyond the transfer length read as zero. Pulls for every register select follow one sequence, only the reported destination differs.

Top module: `stack_xfer_engine`

## Requirements
- R1: The size operand is clamped: any value above 7 acts as 7, and a transfer of size n moves exactly n+1 bytes.
- R2: A push of size n writes byte lane n first (bits 8n+7:8n of the push value), then lanes n-1 down to lane 0, so bits 7:0 are written last.
- R3: Each push byte is written at the current stack pointer with write enable high, after which the stack pointer decreases by one.
- R4: Each pull byte is read from the stack pointer plus one, with write enable low, after which the stack pointer holds that address; the first byte read becomes bits 7:0 and each later byte fills the next higher lane.
- R5: After a pull of size n, all lanes above n of the pulled value are zero, whatever the previous pulled value held.
- R6: After reset the stack pointer is 0xFFFF, busy and done are low and the pulled value is zero.
- R7: Busy is high for exactly n+1 cycles starting the cycle after an accepted start; done is high for exactly one cycle, the cycle after the last byte.
- R8: The stack pointer wraps modulo 2^16 in both directions with no other effect.
- R9: A start strobe while busy is high is ignored: the running transfer keeps its direction, size and data, and no extra transfer follows.
- R10: The register select is reported on the destination output from the cycle after start until the next accepted start (encoding: 0 accumulator, 1 X index, 2 Y index, 3 status word), and every select uses the same pull sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| dir_i | input | 1 | 0 push, 1 pull |
| sel_i | input | 2 | Register select |
| size_i | input | 8 | Size operand byte (clamped to 7) |
| push_val_i | input | 64 | Value to push, sampled at start |
| pull_val_o | output | 64 | Assembled pulled value, final when done is high |
| xfer_sel_o | output | 2 | Register select of the current or last transfer |
| mem_addr_o | output | 16 | Stack memory address |
| mem_wdata_o | output | 8 | Stack memory write data |
| mem_we_o | output | 1 | Stack memory write enable |
| mem_rdata_i | input | 8 | Stack memory read data, same cycle as address |
| sp_o | output | 16 | Current stack pointer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A full eight-byte push followed by a full pull shows that lane order on push and on pull are mirror images, which a value with distinct bytes in every lane separates from any shifted or reversed arrangement. A short push then short pull over a stale wide result tells the zeroing of upper lanes apart from a mere overwrite, and an oversized size operand tells clamping apart from truncation of the low bits. Pulls and pushes across address 0x0000 separate true modulo wrap from saturation, and a second strobe in the middle of a push shows whether the engine re-latches its parameters.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int WORD_BYTES = 8;
    localparam int LANE_W     = $clog2(WORD_BYTES);
    localparam int SIZE_W     = 8;

    typedef enum logic {
        XFER_PUSH = 1'b0,
        XFER_PULL = 1'b1
    } xfer_dir_e;

    typedef enum logic [1:0] {
        REG_ACC    = 2'd0,
        REG_IDX_X  = 2'd1,
        REG_IDX_Y  = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        xfer_dir_e         dir;
        reg_sel_e          sel;
        logic [LANE_W-1:0] top_lane;
    } xfer_ctl_t;

    // Clamp the operand byte to the highest lane index.
    function automatic logic [LANE_W-1:0] clamp_size(input logic [SIZE_W-1:0] sz);
        if (sz > SIZE_W'(WORD_BYTES - 1))
            return LANE_W'(WORD_BYTES - 1);
        return sz[LANE_W-1:0];
    endfunction

endpackage

// File: rtl/stk_pointer.sv
module stk_pointer #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] SP_INIT = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              step_down,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] sp_plus
);
    assign sp_plus = sp + ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            sp <= SP_INIT;
        else if (step_en)
            sp <= step_down ? sp - ADDR_W'(1) : sp_plus;
    end

    // R8: wrap upward from all ones lands on zero
    a_r8_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (step_en && !step_down && sp == '1) |=> (sp == '0));
    // R8: wrap downward from zero lands on all ones
    a_r8_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (step_en && step_down && sp == '0) |=> (sp == '1));
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(sp));
endmodule

// File: rtl/stk_lane_seq.sv
module stk_lane_seq
    import stk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_dir_e         dir,
    input  reg_sel_e          sel,
    input  logic [SIZE_W-1:0] size,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic [LANE_W-1:0] lane,
    output xfer_ctl_t         ctl
);
    logic last_beat;

    assign accept    = start && !busy;
    assign last_beat = (ctl.dir == XFER_PUSH) ? (lane == '0) : (lane == ctl.top_lane);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            lane <= '0;
            ctl  <= '{dir: XFER_PUSH, sel: REG_ACC, top_lane: '0};
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy         <= 1'b1;
                ctl.dir      <= dir;
                ctl.sel      <= sel;
                ctl.top_lane <= clamp_size(size);
                lane         <= (dir == XFER_PUSH) ? clamp_size(size) : '0;
            end else if (busy) begin
                if (last_beat) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else if (ctl.dir == XFER_PUSH) begin
                    lane <= lane - LANE_W'(1);
                end else begin
                    lane <= lane + LANE_W'(1);
                end
            end
        end
    end

    // R7: done lasts a single cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7: busy falling is always accompanied by done
    a_r7_fall_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    // R9: strobe during a transfer leaves the latched control untouched
    a_r9_ignore_start: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(ctl));
    // R1: the lane never exceeds the clamped top lane
    a_r1_lane_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (lane <= ctl.top_lane));
endmodule

// File: rtl/stk_pull_gather.sv
module stk_pull_gather
    import stk_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  logic                      capture,
    input  logic [LANE_W-1:0]         lane,
    input  logic [7:0]                rdata,
    output logic [WORD_BYTES*8-1:0]   value
);
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clear)
                value[g*8 +: 8] <= '0;
            else if (capture && lane == LANE_W'(g))
                value[g*8 +: 8] <= rdata;
        end
    end

    // R5: a new pull starts from an all-zero word
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear |=> (value == '0));
endmodule

// File: rtl/stack_xfer_engine.sv
module stack_xfer_engine
    import stk_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] SP_INIT = '1,
    localparam int WORD_W = WORD_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              dir_i,
    input  logic [1:0]        sel_i,
    input  logic [7:0]        size_i,
    input  logic [WORD_W-1:0] push_val_i,
    output logic [WORD_W-1:0] pull_val_o,
    output logic [1:0]        xfer_sel_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o,
    input  logic [7:0]        mem_rdata_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic              busy_o,
    output logic              done_o
);
    logic              accept;
    logic              busy;
    logic [LANE_W-1:0] lane;
    xfer_ctl_t         ctl;
    logic [ADDR_W-1:0] sp, sp_plus;
    logic [WORD_W-1:0] push_word_q;
    logic              is_push;

    stk_lane_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .dir    (xfer_dir_e'(dir_i)),
        .sel    (reg_sel_e'(sel_i)),
        .size   (size_i),
        .accept (accept),
        .busy   (busy),
        .done   (done_o),
        .lane   (lane),
        .ctl    (ctl)
    );

    assign is_push = (ctl.dir == XFER_PUSH);

    stk_pointer #(.ADDR_W(ADDR_W), .SP_INIT(SP_INIT)) u_sp (
        .clk       (clk),
        .rst       (rst),
        .step_en   (busy),
        .step_down (is_push),
        .sp        (sp),
        .sp_plus   (sp_plus)
    );

    always_ff @(posedge clk) begin
        if (rst)
            push_word_q <= '0;
        else if (accept && xfer_dir_e'(dir_i) == XFER_PUSH)
            push_word_q <= push_val_i;
    end

    always_comb begin
        mem_wdata_o = '0;
        for (int k = 0; k < WORD_BYTES; k++)
            if (lane == LANE_W'(k))
                mem_wdata_o = push_word_q[k*8 +: 8];
    end

    stk_pull_gather u_gather (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept && xfer_dir_e'(dir_i) == XFER_PULL),
        .capture (busy && !is_push),
        .lane    (lane),
        .rdata   (mem_rdata_i),
        .value   (pull_val_o)
    );

    assign mem_addr_o = is_push ? sp : sp_plus;
    assign mem_we_o   = busy && is_push;
    assign sp_o       = sp;
    assign busy_o     = busy;
    assign xfer_sel_o = ctl.sel;

    // R3: every write moves the pointer down by one
    a_r3_push_dec: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |=> (sp_o == $past(sp_o) - ADDR_W'(1)));
    // R4: every pull beat leaves the pointer on the address just read
    a_r4_pull_addr: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !mem_we_o) |=> (sp_o == $past(mem_addr_o)));
    // R7: no write outside a transfer
    a_r7_we_in_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> busy_o);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

// File: tb/stack_xfer_engine_tb_top.sv
module stack_xfer_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        dir_i;
    logic [1:0]  sel_i;
    logic [7:0]  size_i;
    logic [63:0] push_val_i;
    logic [63:0] pull_val_o;
    logic [1:0]  xfer_sel_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        mem_we_o;
    logic [7:0]  mem_rdata_i;
    logic [15:0] sp_o;
    logic        busy_o;
    logic        done_o;

    always #2 clk = ~clk;

    stack_xfer_engine dut_i (.*);

    // Small memory model indexed by the low address byte.
    logic [7:0] mem [0:255];
    assign mem_rdata_i = mem[mem_addr_o[7:0]];
    always @(posedge clk) if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;

    int errs = 0;
    int checks = 0;
    typedef struct { logic [15:0] addr; logic we; logic [7:0] data; } beat_t;
    beat_t exp_q[$];
    int busy_cnt = 0;
    int done_cnt = 0;
    logic [15:0] tb_sp;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compare each busy beat against the scoreboard.
    always @(negedge clk) begin
        if (!rst) begin
            if (busy_o) begin
                busy_cnt++;
                if (exp_q.size() == 0) begin
                    check(0, "R1 extra beat", 64'(mem_addr_o), 64'hDEAD);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    check(mem_addr_o == e.addr, "R3/R4 beat address", 64'(mem_addr_o), 64'(e.addr));
                    check(mem_we_o == e.we, "R3/R4 write enable", 64'(mem_we_o), 64'(e.we));
                    if (e.we)
                        check(mem_wdata_o == e.data, "R2 push byte order", 64'(mem_wdata_o), 64'(e.data));
                end
            end
            if (done_o) done_cnt++;
        end
    end

    task automatic run_xfer(input bit pull, input logic [1:0] sel, input logic [7:0] size,
                            input logic [63:0] val, input bit poke);
        int n;
        logic [63:0] exp_val;
        n = (size > 8'd7) ? 7 : int'(size);
        exp_val = '0;
        if (!pull) begin
            for (int l = n; l >= 0; l--) begin
                exp_q.push_back('{addr: tb_sp, we: 1'b1, data: val[l*8 +: 8]});
                tb_sp = tb_sp - 16'd1;
            end
        end else begin
            for (int l = 0; l <= n; l++) begin
                tb_sp = tb_sp + 16'd1;
                exp_q.push_back('{addr: tb_sp, we: 1'b0, data: 8'h00});
                exp_val[l*8 +: 8] = mem[tb_sp[7:0]];
            end
        end
        busy_cnt = 0;
        done_cnt = 0;
        @(negedge clk);
        start_i = 1'b1; dir_i = pull; sel_i = sel; size_i = size; push_val_i = val;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R9: second strobe with different parameters mid-transfer
            start_i = 1'b1; dir_i = ~pull; sel_i = ~sel; size_i = 8'd0; push_val_i = ~val;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int t = 0; t < 40 && done_cnt == 0; t++) @(negedge clk);
        #1;
        check(done_cnt == 1, "R7 done seen", 64'(done_cnt), 64'd1);
        check(busy_cnt == n + 1, "R1/R7 beat count", 64'(busy_cnt), 64'(n + 1));
        check(exp_q.size() == 0, "R1 all beats", 64'(exp_q.size()), 64'd0);
        check(sp_o == tb_sp, "R3/R4/R8 pointer", 64'(sp_o), 64'(tb_sp));
        check(xfer_sel_o == sel, "R10 destination", 64'(xfer_sel_o), 64'(sel));
        if (pull) check(pull_val_o == exp_val, "R4/R5 pulled value", pull_val_o, exp_val);
        @(negedge clk);
        check(done_o == 1'b0 && done_cnt == 1, "R7 done one cycle", 64'(done_cnt), 64'd1);
        // R9: no follow-on transfer from an ignored strobe
        check(busy_o == 1'b0, "R9 idle after", 64'(busy_o), 64'd0);
        exp_q.delete();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("  Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        rst = 1'b1; start_i = 1'b0; dir_i = 1'b0; sel_i = 2'd0; size_i = 8'd0; push_val_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R6: reset state
        check(sp_o == 16'hFFFF, "R6 pointer reset", 64'(sp_o), 64'hFFFF);
        check(!busy_o && !done_o, "R6 busy/done low", 64'({busy_o, done_o}), 64'd0);
        check(pull_val_o == '0, "R6 pulled value", pull_val_o, 64'd0);
        tb_sp = 16'hFFFF;

        run_xfer(1'b0, 2'd0, 8'd7, 64'h1122334455667788, 1'b0);   // R2 full push
        run_xfer(1'b1, 2'd1, 8'd7, 64'h0, 1'b0);                  // R4 full pull
        check(pull_val_o == 64'h1122334455667788, "R4 round trip", pull_val_o, 64'h1122334455667788);
        run_xfer(1'b0, 2'd2, 8'd2, 64'hAABBCCDDEEFF0102, 1'b0);   // R2 short push
        run_xfer(1'b1, 2'd3, 8'd2, 64'h0, 1'b0);                  // R5 short pull
        check(pull_val_o == 64'h0000000000FF0102, "R5 upper lanes zero", pull_val_o, 64'h0000000000FF0102);
        run_xfer(1'b0, 2'd0, 8'd200, 64'h0F1E2D3C4B5A6978, 1'b0); // R1 clamp
        run_xfer(1'b1, 2'd2, 8'd9, 64'h0, 1'b0);                  // R1 clamp pull
        run_xfer(1'b1, 2'd0, 8'd0, 64'h0, 1'b0);                  // R8 wrap up to 0000
        check(sp_o == 16'h0000, "R8 wrap to zero", 64'(sp_o), 64'h0);
        run_xfer(1'b0, 2'd1, 8'd3, 64'h00000000CAFEF00D, 1'b0);   // R8 wrap down
        run_xfer(1'b1, 2'd1, 8'd3, 64'h0, 1'b0);
        check(pull_val_o == 64'h00000000CAFEF00D, "R8 wrap round trip", pull_val_o, 64'hCAFEF00D);
        run_xfer(1'b0, 2'd3, 8'd5, 64'h0102030405060708, 1'b1);   // R9 strobe while busy
        run_xfer(1'b1, 2'd0, 8'd5, 64'h0, 1'b1);
        check(pull_val_o == 64'h0000030405060708, "R9 data kept", pull_val_o, 64'h0000030405060708);

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule